// File: doc/BRIEF.md
# Dual-Sync Serial Time-Slot Converter

This block moves framed serial words between two independent serial ports. Call them the wide side (P) and the narrow side (A). Each port has its own bit clock and its own frame-sync input. The two bit clocks may run at different rates, and the syncs may fall at any point in each other's frame. A word enters MSB-first after its own side's sync and is captured on the falling edge of the last bit clock of the word. It is then held until the opposite side's sync rises. At that point it is loaded into the opposite side's output shifter and sent out MSB-first. Moving the word from one frame position to another in this way is time-slot conversion.

There are two path modes. In pass mode (`thru_mode`=1), every word is 8 bits in both directions and travels unchanged. In codec mode (`thru_mode`=0), the A side carries 4-bit words. The captured words are handed to an external codec on parallel strobes, and the codec returns the words that the block then serializes. The codec arithmetic itself is not part of the block.

Each output behaves like an open-drain pin. It is modelled as an enable plus a data bit, and the data bit rests at 1 whenever the enable is low. All pins are oversampled by the single system clock through synchronizers and edge detectors.

The codec strobes carry data but have no ready signal, so the block applies no back-pressure. The frame rate cannot stall. A captured word is offered for exactly one cycle and must be taken then. A returned word is accepted in every cycle its valid is high, and the last one before a sync wins.

Top module: `tsc_slot_bridge`

## Requirements
- R1: After reset both output enables are 0, both data outputs are 1, both codec valids are 0, and each side's held word is 8'hFF, so a side's first frame sends all ones.
- R2: An input word is sampled MSB-first on the bit-clock falling edges that follow its own sync rise. It is captured on the Nth such edge. N is 8 on the P side, and on the A side it is 8 in pass mode and 4 in codec mode.
- R3: On its own sync rise, an output loads its held word and drives the MSB. Each later bit-clock rise advances one bit. After exactly N bits the enable drops, on a bit-clock rise, and the data rests at 1.
- R4: In pass mode, a word captured on one side appears unmodified in the next frame of the other side. The hold is one word deep: only the most recent capture is sent, and an unrefreshed hold is sent again.
- R5: If a word's last falling bit-clock edge reaches the pins on the same system-clock edge as the far side's sync rise, the far side sends that fresh word, not the previously held one.
- R6: In codec mode, each P capture raises `enc_valid` for one cycle with the 8-bit word on `enc_word`. Each A capture raises `dec_valid` for one cycle with the 4-bit word on `dec_word`, where the first bit received is bit 3.
- R7: In codec mode, `enc_ret_word` (bit 3 sent first, 4 bits) and `dec_ret_word` (bit 7 sent first, 8 bits) set the words for the next A and P frames. Captured words do not reach the opposite output in this mode.
- R8: In pass mode both codec valids stay 0, and the return strobes have no effect on what either output sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all serial pins |
| rst_n | input | 1 | Active-low reset |
| thru_mode | input | 1 | 1 = pass mode (8/8 bits), 0 = codec mode (8/4 bits) |
| p_bclk | input | 1 | P-side bit clock |
| p_sync | input | 1 | P-side frame sync, rising edge starts a frame |
| p_sdi | input | 1 | P-side serial data in |
| p_sdo | output | 1 | P-side serial data out, 1 when released |
| p_oe | output | 1 | P-side output enable |
| a_bclk | input | 1 | A-side bit clock |
| a_sync | input | 1 | A-side frame sync, rising edge starts a frame |
| a_sdi | input | 1 | A-side serial data in |
| a_sdo | output | 1 | A-side serial data out, 1 when released |
| a_oe | output | 1 | A-side output enable |
| enc_valid | output | 1 | Codec mode: P word captured, one cycle |
| enc_word | output | 8 | Captured P word |
| enc_ret_valid | input | 1 | Codec result for the A output is valid |
| enc_ret_word | input | 4 | Codec result for the A output |
| dec_valid | output | 1 | Codec mode: A word captured, one cycle |
| dec_word | output | 4 | Captured A word |
| dec_ret_valid | input | 1 | Codec result for the P output is valid |
| dec_ret_word | input | 8 | Codec result for the P output |

## Verification
The bench aims one A sync rise at exactly the edge that completes a P word. A design that loads its hold register before forwarding would send the stale earlier word, and a design with an extra latch stage would do the same. The bench checks the release of the output enable one bit after the 4th bit in codec mode and after the 8th bit in pass mode. A fixed window would either truncate pass-mode words or drive the line during the next slot. The bench sends two P words back-to-back and a repeated frame with no new capture, which exposes a hold that queues instead of overwriting or that clears after sending. It also pulses the return strobes in pass mode and sends P words in codec mode, which shows any leakage between the two paths.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic {
    MODE_CODEC = 1'b0,
    MODE_PASS  = 1'b1
  } path_mode_e;

  localparam int unsigned SIDE_P = 0;
  localparam int unsigned SIDE_A = 1;

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tsc_rx.sv
module tsc_rx #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sample_i,
  input  logic              sdi_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              latch_o,
  output logic [WORD_W-1:0] word_o
);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  len_q;
  logic [WORD_W-1:0] sr_q;

  // Word as it stands once the current bit is shifted in.
  assign word_o  = {sr_q[WORD_W-2:0], sdi_i};
  assign latch_o = sample_i && active_q && !start_i &&
                   (cnt_q == (len_q - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= CNT_W'(WORD_W);
      sr_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      len_q    <= len_i;
    end else if (sample_i && active_q) begin
      sr_q <= word_o;
      if (latch_o) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_LATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |=> !latch_o); // R2

  AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < len_q)); // R2

endmodule

// File: rtl/tsc_tx.sv
module tsc_tx #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              sdo_o,
  output logic              oe_o
);

  logic              oe_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  len_q;
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      cnt_q <= '0;
      len_q <= CNT_W'(WORD_W);
      sr_q  <= '1;
    end else if (load_i) begin
      oe_q  <= 1'b1;
      cnt_q <= '0;
      len_q <= len_i;
      sr_q  <= word_i;
    end else if (shift_i && oe_q) begin
      if (cnt_q == (len_q - CNT_W'(1))) begin
        oe_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        sr_q  <= {sr_q[WORD_W-2:0], 1'b1};
      end
    end
  end

  assign oe_o  = oe_q;
  assign sdo_o = oe_q ? sr_q[WORD_W-1] : 1'b1;

  AST_OE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (cnt_q < len_q)); // R3

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> ((len_q != '0) && (len_q <= CNT_W'(WORD_W)))); // R3

  AST_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> $past(shift_i)); // R3

endmodule

// File: rtl/tsc_slot_bridge.sv
module tsc_slot_bridge
  import tsc_pkg::*;
#(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned NARROW_W    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                thru_mode,
  input  logic                p_bclk,
  input  logic                p_sync,
  input  logic                p_sdi,
  output logic                p_sdo,
  output logic                p_oe,
  input  logic                a_bclk,
  input  logic                a_sync,
  input  logic                a_sdi,
  output logic                a_sdo,
  output logic                a_oe,
  output logic                enc_valid,
  output logic [WORD_W-1:0]   enc_word,
  input  logic                enc_ret_valid,
  input  logic [NARROW_W-1:0] enc_ret_word,
  output logic                dec_valid,
  output logic [NARROW_W-1:0] dec_word,
  input  logic                dec_ret_valid,
  input  logic [WORD_W-1:0]   dec_ret_word
);

  localparam int unsigned CNT_W      = $clog2(WORD_W + 1);
  localparam int unsigned PAD_W      = WORD_W - NARROW_W;
  localparam int unsigned PIN_W      = 6;
  localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(NARROW_W);

  path_mode_e mode;
  assign mode = path_mode_e'(thru_mode);

  // Synchronized pins, three per side: bit clock, sync, data.
  logic [PIN_W-1:0] pins_s;

  tsc_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({a_sdi, a_sync, a_bclk, p_sdi, p_sync, p_bclk}),
    .q     (pins_s)
  );

  logic [1:0] bclk_s, sync_s, sdi_s;
  logic [1:0] bclk_q, sync_q;
  logic [1:0] bclk_rise, bclk_fall, sync_rise;

  logic [1:0][CNT_W-1:0]  len_s;
  logic [1:0]             latch;
  logic [1:0][WORD_W-1:0] word;
  logic [1:0][WORD_W-1:0] hold_q;
  logic [1:0][WORD_W-1:0] hold_d;
  logic [1:0]             ret_valid;
  logic [1:0][WORD_W-1:0] ret_word;
  logic [1:0]             sdo, oe;

  assign ret_valid[SIDE_P] = dec_ret_valid;
  assign ret_word[SIDE_P]  = dec_ret_word;
  assign ret_valid[SIDE_A] = enc_ret_valid;
  assign ret_word[SIDE_A]  = {enc_ret_word, {PAD_W{1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= '0;
      sync_q <= '0;
    end else begin
      bclk_q <= bclk_s;
      sync_q <= sync_s;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int unsigned OTHER  = 1 - s;
    localparam bit          NARROW = (s == SIDE_A);

    assign bclk_s[s] = pins_s[3*s];
    assign sync_s[s] = pins_s[3*s+1];
    assign sdi_s[s]  = pins_s[3*s+2];

    assign bclk_rise[s] = bclk_s[s] & ~bclk_q[s];
    assign bclk_fall[s] = ~bclk_s[s] & bclk_q[s];
    assign sync_rise[s] = sync_s[s] & ~sync_q[s];

    assign len_s[s] = (NARROW && (mode == MODE_CODEC)) ? LEN_NARROW : LEN_WIDE;

    tsc_rx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (sync_rise[s]),
      .sample_i (bclk_fall[s]),
      .sdi_i    (sdi_s[s]),
      .len_i    (len_s[s]),
      .latch_o  (latch[s]),
      .word_o   (word[s])
    );

    // Hold next-state; the output shifter loads this value, so a capture
    // landing on the load cycle is forwarded straight through.
    always_comb begin
      hold_d[s] = hold_q[s];
      if (mode == MODE_PASS) begin
        if (latch[OTHER]) hold_d[s] = word[OTHER];
      end else begin
        if (ret_valid[s]) hold_d[s] = ret_word[s];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q[s] <= '1;
      else        hold_q[s] <= hold_d[s];
    end

    tsc_tx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (sync_rise[s]),
      .shift_i (bclk_rise[s]),
      .word_i  (hold_d[s]),
      .len_i   (len_s[s]),
      .sdo_o   (sdo[s]),
      .oe_o    (oe[s])
    );
  end

  assign p_sdo = sdo[SIDE_P];
  assign p_oe  = oe[SIDE_P];
  assign a_sdo = sdo[SIDE_A];
  assign a_oe  = oe[SIDE_A];

  // Codec strobes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_valid <= 1'b0;
      enc_word  <= '0;
      dec_valid <= 1'b0;
      dec_word  <= '0;
    end else begin
      enc_valid <= latch[SIDE_P] && (mode == MODE_CODEC);
      dec_valid <= latch[SIDE_A] && (mode == MODE_CODEC);
      if (latch[SIDE_P] && (mode == MODE_CODEC)) enc_word <= word[SIDE_P];
      if (latch[SIDE_A] && (mode == MODE_CODEC)) dec_word <= word[SIDE_A][NARROW_W-1:0];
    end
  end

  AST_LOAD_DRIVES_P: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise[SIDE_P] |=> p_oe); // R3

  AST_LOAD_DRIVES_A: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise[SIDE_A] |=> a_oe); // R3

  AST_FRESH_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (thru_mode && latch[SIDE_P] && sync_rise[SIDE_A])
      |=> (a_oe && (a_sdo == $past(word[SIDE_P][WORD_W-1])))); // R5

  AST_CODEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (thru_mode && $past(thru_mode)) |-> (!enc_valid && !dec_valid)); // R8

endmodule

// File: tb/tsc_slot_bridge_test.sv
`timescale 1ns/1ps
module tsc_slot_bridge_test;

  localparam int unsigned P_HALF = 8;
  localparam int unsigned A_HALF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thru = 1'b1;
  logic p_bclk = 1'b0, p_sync = 1'b0, p_sdi = 1'b0;
  logic a_bclk = 1'b0, a_sync = 1'b0, a_sdi = 1'b0;
  logic p_sdo, p_oe, a_sdo, a_oe;
  logic enc_valid, dec_valid;
  logic [7:0] enc_word;
  logic [3:0] dec_word;
  logic enc_ret_valid = 1'b0;
  logic [3:0] enc_ret_word = 4'h0;
  logic dec_ret_valid = 1'b0;
  logic [7:0] dec_ret_word = 8'h00;

  int unsigned cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] q_a[$];
  logic [7:0] q_p[$];
  logic [7:0] q_enc[$];
  logic [7:0] q_dec[$];

  always #2.5 clk = ~clk;

  tsc_slot_bridge uut (
    .clk(clk), .rst_n(rst_n), .thru_mode(thru),
    .p_bclk(p_bclk), .p_sync(p_sync), .p_sdi(p_sdi), .p_sdo(p_sdo), .p_oe(p_oe),
    .a_bclk(a_bclk), .a_sync(a_sync), .a_sdi(a_sdi), .a_sdo(a_sdo), .a_oe(a_oe),
    .enc_valid(enc_valid), .enc_word(enc_word),
    .enc_ret_valid(enc_ret_valid), .enc_ret_word(enc_ret_word),
    .dec_valid(dec_valid), .dec_word(dec_word),
    .dec_ret_valid(dec_ret_valid), .dec_ret_word(dec_ret_word)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Free-running bit clocks, advanced away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      cyc = cyc + 1;
      if (cyc % P_HALF == 0) p_bclk = ~p_bclk;
      if (cyc % A_HALF == 0) a_bclk = ~a_bclk;
    end
  end

  // Driver for a P-side word; pushes what the far side should see.
  task automatic p_frame(input logic [7:0] w, input bit align);
    do @(posedge p_bclk); while (align && (cyc % 32 != 24));
    p_sync = 1'b1;
    p_sdi  = w[7];
    if (thru) q_a.push_back(w);
    else      q_enc.push_back(w);
    for (int i = 6; i >= 0; i--) begin
      @(posedge p_bclk);
      p_sync = 1'b0;
      p_sdi  = w[i];
    end
    repeat (3) @(negedge p_bclk);
  endtask

  // Driver for an A-side word of n bits, starting no earlier than at_cyc.
  task automatic a_frame(input logic [7:0] w, input int n, input int unsigned at_cyc);
    do @(posedge a_bclk); while (cyc < at_cyc);
    a_sync = 1'b1;
    a_sdi  = w[n-1];
    if (thru) q_p.push_back(w);
    else      q_dec.push_back({4'h0, w[3:0]});
    for (int i = n - 2; i >= 0; i--) begin
      @(posedge a_bclk);
      a_sync = 1'b0;
      a_sdi  = w[i];
    end
    repeat (3) @(negedge a_bclk);
  endtask

  task automatic ret_to_a(input logic [3:0] w);
    @(negedge clk);
    enc_ret_valid = 1'b1;
    enc_ret_word  = w;
    @(negedge clk);
    enc_ret_valid = 1'b0;
    if (!thru) q_a.push_back({4'h0, w});
  endtask

  task automatic ret_to_p(input logic [7:0] w);
    @(negedge clk);
    dec_ret_valid = 1'b1;
    dec_ret_word  = w;
    @(negedge clk);
    dec_ret_valid = 1'b0;
    if (!thru) q_p.push_back(w);
  endtask

  // Monitor: A output frames.
  initial begin
    forever begin
      logic [7:0] exp, got, mask;
      int n;
      bit oe_ok;
      @(posedge a_sync);
      n = thru ? 8 : 4;
      mask = thru ? 8'hFF : 8'h0F;
      if (q_a.size() == 0) begin
        exp = 8'hxx;
        check(1'b0, "R4 A frame with nothing expected", 0, 0);
      end else begin
        exp = q_a.pop_front();
      end
      got = 8'h00;
      oe_ok = 1'b1;
      for (int i = 0; i < n; i++) begin
        @(negedge a_bclk); #1;
        got = {got[6:0], a_sdo};
        if (!a_oe) oe_ok = 1'b0;
      end
      check(oe_ok && ((got & mask) == (exp & mask)), "R3/R4/R5/R7 A word",
            {23'd0, oe_ok, got & mask}, {24'd1, exp & mask});
      @(negedge a_bclk); #1;
      check(!a_oe && a_sdo, "R3 A released after window", {a_oe, a_sdo}, 2'b01);
    end
  end

  // Monitor: P output frames.
  initial begin
    forever begin
      logic [7:0] exp, got;
      bit oe_ok;
      @(posedge p_sync);
      if (q_p.size() == 0) begin
        exp = 8'hxx;
        check(1'b0, "R4 P frame with nothing expected", 0, 0);
      end else begin
        exp = q_p.pop_front();
      end
      got = 8'h00;
      oe_ok = 1'b1;
      for (int i = 0; i < 8; i++) begin
        @(negedge p_bclk); #1;
        got = {got[6:0], p_sdo};
        if (!p_oe) oe_ok = 1'b0;
      end
      check(oe_ok && (got == exp), "R2/R3/R4/R7 P word", {23'd0, oe_ok, got}, {24'd1, exp});
      @(negedge p_bclk); #1;
      check(!p_oe && p_sdo, "R3 P released after window", {p_oe, p_sdo}, 2'b01);
    end
  end

  // Monitor: codec strobes.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && enc_valid) begin
        if (q_enc.size() == 0) check(1'b0, "R8 unexpected enc_valid", 1, 0);
        else begin
          logic [7:0] e;
          e = q_enc.pop_front();
          check(enc_word == e, "R6 enc_word", enc_word, e);
        end
      end
      if (rst_n && dec_valid) begin
        if (q_dec.size() == 0) check(1'b0, "R8 unexpected dec_valid", 1, 0);
        else begin
          logic [7:0] e;
          e = q_dec.pop_front();
          check({4'h0, dec_word} == e, "R6 dec_word", dec_word, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned tgt;
    repeat (20) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check(!p_oe && !a_oe && p_sdo && a_sdo && !enc_valid && !dec_valid,
          "R1 reset state", {p_oe, a_oe, p_sdo, a_sdo, enc_valid, dec_valid}, 6'b001100);
    q_a.push_back(8'hFF); // R1: held word after reset is all ones

    // Pass mode, alternating sides, distinct patterns (R2, R4)
    a_frame(8'h3C, 8, 0);
    p_frame(8'hA5, 1'b0);
    a_frame(8'h81, 8, 0);
    p_frame(8'h00, 1'b0);

    // R8: return strobes ignored in pass mode
    ret_to_a(4'h6);
    ret_to_p(8'h77);
    a_frame(8'hFF, 8, 0);
    p_frame(8'h5A, 1'b0);

    // R4: one-deep hold, repeat of unrefreshed word, overwrite by newer word
    q_p.push_back(8'hFF);
    p_frame(8'hC3, 1'b0);
    void'(q_a.pop_front());
    a_frame(8'h12, 8, 0);

    // R5: A sync rise on the same edge as the last P bit-clock fall
    fork
      p_frame(8'hE7, 1'b1);
      begin
        @(posedge p_sync);
        tgt = cyc + 120;
        a_frame(8'h4B, 8, tgt);
      end
    join
    p_frame(8'h99, 1'b0);
    void'(q_a.pop_front());

    // Codec mode (R6, R7)
    @(negedge clk);
    thru = 1'b0;
    ret_to_a(4'h9);
    ret_to_p(8'h6E);
    p_frame(8'hB4, 1'b0);
    a_frame(8'h0D, 4, 0);
    q_a.push_back(8'h09);
    a_frame(8'h02, 4, 0);
    q_p.push_back(8'h6E);
    p_frame(8'h0F, 1'b0);
    ret_to_a(4'h0);
    a_frame(8'h0F, 4, 0);

    repeat (200) @(negedge clk);
    check(q_a.size() == 0 && q_p.size() == 0 && q_enc.size() == 0 && q_dec.size() == 0,
          "R4/R6 all expected items seen",
          q_a.size() + q_p.size() + q_enc.size() + q_dec.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule